// File: doc/BRIEF.md
# Tagged Result Broadcast Arbiter

This block sits between the units that finish floating-point work and the units waiting for those results. It takes results from eleven producers (three adder stations, two multiply/divide stations and six load buffers) and puts them on one shared result bus, one per cycle. Each result goes out as a pair: a short code naming the producer, and the value. Listeners match on the producer code, not on a register number. Matching in the listeners is outside this block.

A producer asks for the bus two cycles before its value appears. It raises its request together with its data and keeps both steady until it sees its grant. The grant pulse and the broadcast fall in the same cycle. When several producers ask at once, a rotating priority picks one winner and the others wait, so no producer starves. All outputs come straight from flip-flops, and reset is synchronous and active-high.

Top module: `result_bus_arbiter`

## Requirements
- R1: During and after a synchronous reset, every grant, the valid flag, the tag and the value are zero, and the rotating priority restarts with producer index 0 as most favoured.
- R2: A request raised in cycle t with no other contender gives a grant pulse and a valid broadcast in cycle t+2, and not in cycle t+1.
- R3: At most one grant bit is high in any cycle, and the bus valid flag is high exactly when one grant bit is high.
- R4: Producer bit positions are the three adders at indices 0..2, then the two multiply/divide stations at 3..4, then the six load buffers at 5..10. A broadcast from index i carries tag i+1, so tags run 1..11 and tag 0 never comes with a valid flag.
- R5: Among the producers still pending, the winner is the first index after the previous winner, taken cyclically.
- R6: A producer that keeps its request high is granted within N cycles of entering arbitration, where N is the number of producers. Held requests are never dropped.
- R7: The value on the bus equals the data the granted producer presented with its request.
- R8: In a cycle with no grant, the bus valid flag is low and the tag and value are zero.
- R9: If a producer keeps its request high in its grant cycle, that counts as a fresh request and is granted again two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_req_i | input | N_ADD+N_MUL+N_LD | One request bit per producer, held until granted |
| prod_data_i | input | (N_ADD+N_MUL+N_LD)*DATA_W | Result values, producer i in bits i*DATA_W +: DATA_W |
| prod_gnt_o | output | N_ADD+N_MUL+N_LD | One-cycle grant pulse, in the cycle of the broadcast |
| bus_valid_o | output | 1 | Broadcast present this cycle |
| bus_tag_o | output | TAG_W | Producer code of the broadcast, 0 when idle |
| bus_value_o | output | DATA_W | Broadcast value, 0 when idle |

## Verification
The bench builds the block with the default producer mix of three, two and six, which gives eleven tags and makes the wrap of the rotating pointer from index 10 back to 0 reachable. It narrows DATA_W to 16, so each producer and each vector gets its own recognisable value. A reference model of rotating priority runs in the bench and predicts each winner from the request masks. The full eleven-way contention drives the longest wait, which the wait-bound check covers.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int TAG_W    = 4;
  localparam int TAG_NONE = 0;
endpackage

// File: rtl/crb_req_latch.sv
// First lead-time stage: holds the request set that arbitration sees next cycle.
// The producer granted this cycle is masked out, so a request it still holds
// is not counted twice.
module crb_req_latch #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] win_i,
  output logic [N-1:0] req_q
);
  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= req_i & ~win_i;
  end
endmodule

// File: rtl/crb_rr_pick.sv
// Rotating-priority picker: the search starts one past the previous winner.
module crb_rr_pick #(
  parameter int N = 11,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req_q,
  output logic [N-1:0]     win,
  output logic [IDX_W-1:0] win_idx,
  output logic             any
);
  logic [IDX_W-1:0] last_q;

  always_comb begin
    int k;
    win_idx = '0;
    // Walk from farthest to nearest so the nearest pending index wins.
    for (int off = N; off >= 1; off--) begin
      k = int'(last_q) + off;
      if (k >= N) k = k - N;
      if (req_q[k]) win_idx = IDX_W'(k);
    end
    any = |req_q;
    win = any ? ({{(N-1){1'b0}}, 1'b1} << win_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)      last_q <= IDX_W'(N - 1);
    else if (any) last_q <= win_idx;
  end

  AST_PICK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(last_q) < N);  // R5
endmodule

// File: rtl/crb_bus_drive.sv
// Second lead-time stage: registers the grant and the tag/value broadcast.
module crb_bus_drive #(
  parameter int N      = 11,
  parameter int DATA_W = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int TAG_W = crb_pkg::TAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      win,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic              any,
  input  logic [N*DATA_W-1:0] data_i,
  output logic [N-1:0]      gnt_o,
  output logic              valid_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] value_o
);
  logic [IDX_W:0] tag_wide;
  assign tag_wide = {1'b0, win_idx} + (IDX_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_o   <= '0;
      valid_o <= 1'b0;
      tag_o   <= TAG_W'(crb_pkg::TAG_NONE);
      value_o <= '0;
    end else begin
      gnt_o   <= win;
      valid_o <= any;
      tag_o   <= any ? TAG_W'(tag_wide) : TAG_W'(crb_pkg::TAG_NONE);
      value_o <= any ? data_i[int'(win_idx)*DATA_W +: DATA_W] : '0;
    end
  end
endmodule

// File: rtl/result_bus_arbiter.sv
module result_bus_arbiter #(
  parameter int N_ADD  = 3,
  parameter int N_MUL  = 2,
  parameter int N_LD   = 6,
  parameter int DATA_W = 32,
  localparam int N     = N_ADD + N_MUL + N_LD,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int TAG_W = crb_pkg::TAG_W,
  localparam int CNT_W = $clog2(N + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        prod_req_i,
  input  logic [N*DATA_W-1:0] prod_data_i,
  output logic [N-1:0]        prod_gnt_o,
  output logic                bus_valid_o,
  output logic [TAG_W-1:0]    bus_tag_o,
  output logic [DATA_W-1:0]   bus_value_o
);
  logic [N-1:0]     req_q;
  logic [N-1:0]     win;
  logic [IDX_W-1:0] win_idx;
  logic             any;

  crb_req_latch #(.N(N)) u_latch (
    .clk(clk), .rst(rst), .req_i(prod_req_i), .win_i(win), .req_q(req_q)
  );

  crb_rr_pick #(.N(N)) u_pick (
    .clk(clk), .rst(rst), .req_q(req_q),
    .win(win), .win_idx(win_idx), .any(any)
  );

  crb_bus_drive #(.N(N), .DATA_W(DATA_W)) u_drive (
    .clk(clk), .rst(rst), .win(win), .win_idx(win_idx), .any(any),
    .data_i(prod_data_i), .gnt_o(prod_gnt_o), .valid_o(bus_valid_o),
    .tag_o(bus_tag_o), .value_o(bus_value_o)
  );

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(prod_gnt_o));  // R3
  AST_VALID_IFF_GRANT: assert property (@(posedge clk) disable iff (rst)
    bus_valid_o == ($countones(prod_gnt_o) == 1));  // R3
  AST_TAG_NONZERO: assert property (@(posedge clk) disable iff (rst)
    bus_valid_o |-> bus_tag_o != '0);  // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bus_valid_o |-> (bus_tag_o == '0 && bus_value_o == '0));  // R8

  for (genvar i = 0; i < N; i++) begin : g_prod
    logic [CNT_W-1:0] wait_cnt;
    always_ff @(posedge clk) begin
      if (rst || !req_q[i] || win[i]) wait_cnt <= '0;
      else                             wait_cnt <= wait_cnt + CNT_W'(1);
    end
    AST_GRANT_LEAD: assert property (@(posedge clk) disable iff (rst)
      prod_gnt_o[i] |-> $past(prod_req_i[i], 2));  // R2
    AST_NO_STARVE: assert property (@(posedge clk) disable iff (rst)
      int'(wait_cnt) < N);  // R6
  end
endmodule

// File: tb/result_bus_arbiter_tb_top.sv
`timescale 1ns/100ps
module result_bus_arbiter_tb_top;
  localparam int N = 11;
  localparam int W = 16;
  localparam int NV = 8;
  localparam logic [N-1:0] VEC [NV] = '{
    11'b000_0000_0001, 11'b111_1111_1111, 11'b100_0000_0001, 11'b000_0010_0100,
    11'b010_1010_1010, 11'b000_0001_1000, 11'b101_0000_0000, 11'b000_0000_0110
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]   req = '0;
  logic [N*W-1:0] data = '0;
  logic [N-1:0]   gnt;
  logic           valid;
  logic [3:0]     tag;
  logic [W-1:0]   value;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int ptr = N - 1;

  always #2.5 clk = ~clk;

  result_bus_arbiter #(.DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .prod_req_i(req), .prod_data_i(data),
    .prod_gnt_o(gnt), .bus_valid_o(valid), .bus_tag_o(tag), .bus_value_o(value)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic chk_idle(input string rq);
    chk(gnt == '0 && !valid && tag == 4'd0 && value == '0, rq,
        {gnt, valid, tag, value}, 64'd0);
  endtask

  function automatic int next_win(input logic [N-1:0] pend);
    for (int off = 1; off <= N; off++) begin
      int k = (ptr + off) % N;
      if (pend[k]) return k;
    end
    return -1;
  endfunction

  task automatic load_data(input int v);
    for (int i = 0; i < N; i++) data[i*W +: W] = W'(v*256 + i*16 + 5);
  endtask

  // Called right after the negedge that follows the launch; grants start at the next one.
  task automatic drain(input logic [N-1:0] mask);
    logic [N-1:0] pend = mask;
    for (int g = 0; g < $countones(mask); g++) begin
      int w;
      @(negedge clk);
      w = next_win(pend);
      chk(gnt == (N'(1) << w), "R5 winner order", 64'(gnt), 64'(N'(1) << w));
      chk(valid == 1'b1, "R3 valid with grant", 64'(valid), 64'd1);
      chk(tag == 4'(w + 1), "R4 tag of producer", 64'(tag), 64'(w + 1));
      chk(value == data[w*W +: W], "R7 broadcast value", 64'(value), 64'(data[w*W +: W]));
      pend[w] = 1'b0;
      req[w] = 1'b0;
      ptr = w;
    end
    @(negedge clk);
    chk_idle("R6 R8 all held requests served, bus idle");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 outputs cleared in reset");
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1 outputs idle after reset");

    // Table of launch masks; each producer holds until granted.
    for (int v = 0; v < NV; v++) begin
      load_data(v);
      req = VEC[v];
      @(negedge clk);
      chk_idle("R2 no broadcast one cycle after request");
      drain(VEC[v]);
    end

    // R1: reset with requests pending clears outputs and restarts priority at index 0.
    load_data(9);
    req = '1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk_idle("R1 reset clears pending broadcast");
    rst = 1'b0;
    ptr = N - 1;
    @(negedge clk);
    chk_idle("R2 no broadcast one cycle after reset release");
    drain('1);

    // R9: request held through the grant cycle is granted again two cycles later.
    load_data(10);
    req[3] = 1'b1;
    @(negedge clk);
    chk_idle("R2 lone request, t+1 quiet");
    @(negedge clk);
    chk(gnt == 11'b000_0000_1000 && tag == 4'd4, "R2 lone request granted at t+2",
        {gnt, tag}, {11'b000_0000_1000, 4'd4});
    data[3*W +: W] = 16'hBEEF;
    @(negedge clk);
    chk_idle("R9 gap cycle after regrant request");
    @(negedge clk);
    chk(gnt[3] && valid && value == 16'hBEEF, "R9 fresh request regranted",
        {gnt, valid, value}, {11'b000_0000_1000, 1'b1, 16'hBEEF});
    req[3] = 1'b0;
    @(negedge clk);
    chk_idle("R8 idle after regrant");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule